// File: doc/BRIEF.md
# Byte-serial instruction decoder core

A small 8-bit-bus processor core that reads variable-length instructions one byte at a time from a synchronous memory port and runs a reduced instruction subset. The upper four bits of the first byte pick the operation class. Bit 4 of the first byte selects byte width when 0 and word width when 1, for the load, store and implicit-register classes. Instructions are 1, 2 or 3 bytes long, and every byte after the first carries addressing data. That data is either a big-endian 16-bit direct address, a signed 8-bit displacement, or an index post-byte.

The memory port is synchronous. An address driven in one cycle returns its byte in the next cycle. A write takes effect at the clock edge that ends the cycle in which write enable is high. The architectural state is:
- the low accumulator byte (AL);
- a link flag and a zero flag;
- a 16-bit index register (XW);
- a return stack with a fixed depth.

An opcode outside the subset, or a stack misuse, stops the core. It then raises `halt_o` and holds it until reset.

Top module: `bsd_core`

## Requirements
- R1: While rst_ni is low, halt_o and mem_we_o are 0 and mem_addr_o equals RESET_PC (default 0x0000). AL, link, zero and XW start cleared, and the return stack starts empty.
- R2: 0x81 hi lo loads the byte at address {hi,lo} into AL. It sets zero exactly when that byte is 0.
- R3: 0xA1 hi lo writes AL to {hi,lo}. mem_we_o is high for exactly one cycle, the fifth cycle of the instruction, with mem_wdata_o equal to AL.
- R4: 0x2C (1 byte) shifts AL left by one bit. Link takes the old bit 7, and zero is set when the shifted result is 0.
- R5: 0x11 d branches when link is 0. The target is the address after the 2-byte instruction plus the sign-extended d. Otherwise execution falls through.
- R6: 0x15 d branches the same way when zero is 0.
- R7: 0x85 0x41 loads AL from the address held in XW, updates zero from the loaded byte, then increments XW. 0x60 hi lo loads XW with {hi,lo}.
- R8: 0x73 d always jumps to the address after the instruction plus the sign-extended d.
- R9: 0x79 hi lo pushes the address of the following instruction and jumps to {hi,lo}. 0x09 pops the most recent pushed address into the PC.
- R10: The return stack holds 4 entries. A fifth nested call halts the core, and so does a return with an empty stack. Neither case performs a write.
- R11: Every other first byte halts the core. This includes the word-width forms 0x91 and 0xB1, and 0x85 followed by any post-byte other than 0x41. Once halted, halt_o stays 1, mem_we_o stays 0 and mem_addr_o is held until reset.
- R12: Cycle counts per instruction are:
  - 2 for 1-byte instructions and halting opcodes;
  - 3 for branches, jumps and a bad index post-byte;
  - 4 for calls and the XW load;
  - 5 for indexed loads and stores;
  - 6 for direct loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory byte address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after its address |
| mem_wdata_o | output | 8 | Write data (AL) |
| mem_we_o | output | 1 | Write enable, one cycle per store |
| halt_o | output | 1 | Halted on illegal opcode or stack misuse |

## Verification
The cycle count of every instruction is fixed, so the bench counts clock edges from the release of reset and derives the due edge of every result from the per-instruction counts in R12. A halt becomes visible on the edge that ends the offending instruction. A store's write lands on the fifth edge of that store. The bench samples outputs on the falling edge and compares both the halting edge and the first write edge against these sums. It then reads the resulting memory image, which reveals AL, link and zero through conditional stores.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef enum logic [3:0] {
    K_BAD, K_LDA, K_STA, K_SHL, K_BNL, K_BNZ, K_LDI, K_JMP, K_RET, K_CALL, K_LDX
  } kind_e;

  typedef enum logic [2:0] {
    S_FETCH, S_OP, S_B1, S_B2, S_MEM, S_LD, S_HALT
  } state_e;

  localparam logic [7:0] IDX_POST = 8'h41;  // XW source, post-increment
endpackage

// File: rtl/bsd_decode.sv
module bsd_decode
  import bsd_pkg::*;
(
  input  logic [7:0] op_i,
  output kind_e      kind_o
);
  logic [3:0] cls, lo;
  logic       is_word;

  assign cls     = op_i[7:4];
  assign lo      = op_i[3:0];
  assign is_word = op_i[4];  // width bit, meaningful for classes 2/3, 8/9, A/B

  always_comb begin
    kind_o = K_BAD;
    case (cls)
      4'h0: if (lo == 4'h9) kind_o = K_RET;
      4'h1: begin
        if (lo == 4'h1) kind_o = K_BNL;
        if (lo == 4'h5) kind_o = K_BNZ;
      end
      4'h2, 4'h3: if (!is_word && lo == 4'hC) kind_o = K_SHL;
      4'h6: if (lo == 4'h0) kind_o = K_LDX;
      4'h7: begin
        if (lo == 4'h3) kind_o = K_JMP;
        if (lo == 4'h9) kind_o = K_CALL;
      end
      4'h8, 4'h9: if (!is_word) begin
        if (lo == 4'h1) kind_o = K_LDA;
        if (lo == 4'h5) kind_o = K_LDI;
      end
      4'hA, 4'hB: if (!is_word && lo == 4'h1) kind_o = K_STA;
      default: kind_o = K_BAD;
    endcase
  end
endmodule

// File: rtl/bsd_shl.sv
module bsd_shl #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o,
  output logic          zero_o
);
  assign res_o   = {a_i[DW-2:0], 1'b0};
  assign carry_o = a_i[DW-1];
  assign zero_o  = (res_o == '0);
endmodule

// File: rtl/bsd_rstack.sv
module bsd_rstack #(
  parameter  int AW    = 16,
  parameter  int DEPTH = 4,
  localparam int SPW   = $clog2(DEPTH + 1),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic [AW-1:0]  din_i,
  output logic [AW-1:0]  dout_o,
  output logic           full_o,
  output logic           empty_o,
  output logic [SPW-1:0] cnt_o
);
  logic [AW-1:0]  ent_q [DEPTH];
  logic [SPW-1:0] cnt_q;
  logic [SPW-1:0] top_idx;

  assign full_o  = (cnt_q == SPW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
  assign top_idx = cnt_q - 1'b1;
  assign dout_o  = ent_q[top_idx[IW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (push_i && !full_o) begin
      for (int i = 0; i < DEPTH; i++)
        if (cnt_q == SPW'(i)) ent_q[i] <= din_i;
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/bsd_core.sv
module bsd_core
  import bsd_pkg::*;
#(
  parameter  int            DW          = 8,
  parameter  int            STACK_DEPTH = 4,
  parameter  logic [15:0]   RESET_PC    = 16'h0000,
  parameter  logic [15:0]   XW_RESET    = 16'h0000,
  localparam int            AW          = 2 * DW,
  localparam int            SP_W        = $clog2(STACK_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          halt_o
);
  state_e        state_q;
  kind_e         ir_q, dec_kind;
  logic [AW-1:0] pc_q, ea_q, xw_q;
  logic [DW-1:0] al_q, hi_q;
  logic          link_q, zero_q, idx_q, halt_q;

  logic [AW-1:0] pc_inc, br_tgt, ea_full, stk_top;
  logic [DW-1:0] shl_res;
  logic          shl_c, shl_z;
  logic          stk_push, stk_pop, stk_full, stk_empty;
  logic [SP_W-1:0] stk_cnt;

  bsd_decode u_dec (.op_i(mem_rdata_i), .kind_o(dec_kind));

  bsd_shl #(.DW(DW)) u_shl (
    .a_i(al_q), .res_o(shl_res), .carry_o(shl_c), .zero_o(shl_z)
  );

  bsd_rstack #(.AW(AW), .DEPTH(STACK_DEPTH)) u_stk (
    .clk_i, .rst_ni,
    .push_i(stk_push), .pop_i(stk_pop), .din_i(pc_inc),
    .dout_o(stk_top), .full_o(stk_full), .empty_o(stk_empty), .cnt_o(stk_cnt)
  );

  assign pc_inc  = pc_q + 1'b1;
  // pc_q points at the displacement byte in S_B1
  assign br_tgt  = pc_inc + {{(AW-DW){mem_rdata_i[DW-1]}}, mem_rdata_i};
  assign ea_full = {hi_q, mem_rdata_i};

  assign stk_push = (state_q == S_B2) && (ir_q == K_CALL) && !stk_full;
  assign stk_pop  = (state_q == S_OP) && (dec_kind == K_RET) && !stk_empty;

  always_comb begin
    case (state_q)
      S_OP, S_B1:   mem_addr_o = pc_inc;
      S_MEM, S_LD:  mem_addr_o = ea_q;
      default:      mem_addr_o = pc_q;
    endcase
  end

  assign mem_we_o    = (state_q == S_MEM) && (ir_q == K_STA);
  assign mem_wdata_o = al_q;
  assign halt_o      = halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      ir_q    <= K_BAD;
      pc_q    <= RESET_PC;
      ea_q    <= '0;
      xw_q    <= XW_RESET;
      al_q    <= '0;
      hi_q    <= '0;
      link_q  <= 1'b0;
      zero_q  <= 1'b0;
      idx_q   <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      case (state_q)
        S_FETCH: state_q <= S_OP;
        S_OP: begin
          ir_q <= dec_kind;
          case (dec_kind)
            K_BAD: begin
              halt_q  <= 1'b1;
              state_q <= S_HALT;
            end
            K_SHL: begin
              al_q    <= shl_res;
              link_q  <= shl_c;
              zero_q  <= shl_z;
              pc_q    <= pc_inc;
              state_q <= S_FETCH;
            end
            K_RET: begin
              if (stk_empty) begin
                halt_q  <= 1'b1;
                state_q <= S_HALT;
              end else begin
                pc_q    <= stk_top;
                state_q <= S_FETCH;
              end
            end
            default: begin
              pc_q    <= pc_inc;
              state_q <= S_B1;
            end
          endcase
        end
        S_B1: begin
          case (ir_q)
            K_BNL: begin
              pc_q    <= link_q ? pc_inc : br_tgt;
              state_q <= S_FETCH;
            end
            K_BNZ: begin
              pc_q    <= zero_q ? pc_inc : br_tgt;
              state_q <= S_FETCH;
            end
            K_JMP: begin
              pc_q    <= br_tgt;
              state_q <= S_FETCH;
            end
            K_LDI: begin
              if (mem_rdata_i == IDX_POST) begin
                ea_q    <= xw_q;
                idx_q   <= 1'b1;
                pc_q    <= pc_inc;
                state_q <= S_MEM;
              end else begin
                halt_q  <= 1'b1;
                state_q <= S_HALT;
              end
            end
            default: begin
              hi_q    <= mem_rdata_i;
              pc_q    <= pc_inc;
              state_q <= S_B2;
            end
          endcase
        end
        S_B2: begin
          case (ir_q)
            K_CALL: begin
              if (stk_full) begin
                halt_q  <= 1'b1;
                state_q <= S_HALT;
              end else begin
                pc_q    <= ea_full;
                state_q <= S_FETCH;
              end
            end
            K_LDX: begin
              xw_q    <= ea_full;
              pc_q    <= pc_inc;
              state_q <= S_FETCH;
            end
            default: begin
              ea_q    <= ea_full;
              idx_q   <= 1'b0;
              pc_q    <= pc_inc;
              state_q <= S_MEM;
            end
          endcase
        end
        S_MEM: state_q <= (ir_q == K_STA) ? S_FETCH : S_LD;
        S_LD: begin
          al_q    <= mem_rdata_i;
          zero_q  <= (mem_rdata_i == '0);
          if (idx_q) xw_q <= xw_q + 1'b1;
          state_q <= S_FETCH;
        end
        default: state_q <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/bsd_core_chk.sv
module bsd_core_chk #(
  parameter  int AW    = 16,
  parameter  int DEPTH = 4,
  localparam int SPW   = $clog2(DEPTH + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [AW-1:0]  mem_addr_i,
  input logic           mem_we_i,
  input logic           halt_i,
  input logic [SPW-1:0] sp_cnt_i
);
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> halt_i);  // R11

  AST_HALT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> !mem_we_i);  // R11

  AST_HALT_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> $stable(mem_addr_i));  // R11

  AST_WRITE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i);  // R3

  AST_STACK_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_cnt_i <= SPW'(DEPTH));  // R10

  AST_STACK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_cnt_i == $past(sp_cnt_i)) || (sp_cnt_i == $past(sp_cnt_i) + 1'b1)
      || (sp_cnt_i == $past(sp_cnt_i) - 1'b1));  // R9
endmodule

bind bsd_core bsd_core_chk #(.AW(AW), .DEPTH(STACK_DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_addr_i (mem_addr_o),
  .mem_we_i   (mem_we_o),
  .halt_i     (halt_o),
  .sp_cnt_i   (stk_cnt)
);

// File: tb/tb_bsd_core.sv
module tb_bsd_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr;
  logic [7:0]  rdata;
  logic [7:0]  wdata;
  logic        we, halt;
  logic [7:0]  mem [0:1023];
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsd_core dut (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(addr), .mem_rdata_i(rdata),
    .mem_wdata_o(wdata), .mem_we_o(we), .halt_o(halt)
  );

  always @(posedge clk) begin
    if (we) mem[addr[9:0]] <= wdata;
    rdata <= mem[addr[9:0]];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    mem[10'h300] = 8'hEE;
    mem[10'h301] = 8'hEE;
    mem[10'h302] = 8'hEE;
  endtask

  task automatic put3(input int a, input int b0, input int b1, input int b2);
    mem[a] = 8'(b0); mem[a+1] = 8'(b1); mem[a+2] = 8'(b2);
  endtask

  // runs from reset to halt; edges counted from reset release
  task automatic run(output int edges, output int first_w, output bit post_ok);
    logic [15:0] a;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk(!halt && !we && addr == 16'h0000, "R1 reset state", {halt, we, addr}, 0);
    rst_ni = 1'b1;
    edges = 0; first_w = 0; post_ok = 1'b1;
    while (!halt && edges < 400) begin
      if (we && first_w == 0) first_w = edges + 1;
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
    if (!halt) chk(1'b0, "R12 run timeout", edges, 400);
    a = addr;
    repeat (4) begin
      @(negedge clk);
      if (we || addr != a || !halt) post_ok = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int  e, fw;
    bit  pk;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    @(negedge clk);
    chk(!halt && !we && addr == 16'h0000, "R1 initial reset", {halt, we, addr}, 0);

    // load / shift / store / BNL / BNZ sweep over every data byte
    for (int v = 0; v < 256; v++) begin
      int sh, ln, zr, exp_e;
      clr();
      put3(0, 8'h81, 8'h02, 8'h00);
      mem[3] = 8'h2C;
      put3(4, 8'hA1, 8'h03, 8'h00);
      mem[7] = 8'h11; mem[8] = 8'h03;
      put3(9, 8'hA1, 8'h03, 8'h01);
      mem[12] = 8'h15; mem[13] = 8'h03;
      put3(14, 8'hA1, 8'h03, 8'h02);
      mem[17] = 8'hFF;
      mem[10'h200] = 8'(v);
      sh = (v << 1) & 255;
      ln = (v >> 7) & 1;
      zr = (sh == 0) ? 1 : 0;
      exp_e = 21 + (ln ? 5 : 0) + (zr ? 5 : 0);
      run(e, fw, pk);
      chk(mem[10'h300] == 8'(sh), "R2 R4 shifted AL", mem[10'h300], sh);
      chk(mem[10'h301] == (ln ? 8'(sh) : 8'hEE), "R5 branch on link clear",
          mem[10'h301], ln ? sh : 8'hEE);
      chk(mem[10'h302] == (zr ? 8'h00 : 8'hEE), "R6 branch on not zero",
          mem[10'h302], zr ? 0 : 8'hEE);
      chk(e == exp_e, "R12 total cycles", e, exp_e);
      chk(fw == 13, "R3 store write edge", fw, 13);
    end

    // indexed load with post-increment, zero flag from loads
    for (int ai = 0; ai < 4; ai++) begin
      for (int b = 0; b < 256; b++) begin
        int av, exp_e;
        av = (ai == 0) ? 0 : (ai == 1) ? 1 : (ai == 2) ? 8'h80 : 8'hFF;
        clr();
        put3(0, 8'h60, 8'h02, 8'h00);
        mem[3] = 8'h85; mem[4] = 8'h41;
        mem[5] = 8'h15; mem[6] = 8'h03;
        put3(7, 8'hA1, 8'h03, 8'h02);
        mem[10] = 8'h85; mem[11] = 8'h41;
        put3(12, 8'hA1, 8'h03, 8'h00);
        mem[15] = 8'hFF;
        mem[10'h200] = 8'(av);
        mem[10'h201] = 8'(b);
        exp_e = 24 + ((av == 0) ? 5 : 0);
        run(e, fw, pk);
        chk(mem[10'h300] == 8'(b), "R7 indexed load after increment", mem[10'h300], b);
        chk(mem[10'h302] == ((av == 0) ? 8'h00 : 8'hEE), "R7 R2 zero from load",
            mem[10'h302], (av == 0) ? 0 : 8'hEE);
        chk(e == exp_e, "R12 indexed cycles", e, exp_e);
      end
    end

    // forward and backward relative jumps
    clr();
    mem[0] = 8'h73; mem[1] = 8'h06;
    put3(2, 8'hA1, 8'h03, 8'h00);
    mem[5] = 8'hFF;
    mem[8] = 8'h73; mem[9] = 8'hF8;
    run(e, fw, pk);
    chk(mem[10'h300] == 8'h00, "R8 jump forward then back", mem[10'h300], 0);
    chk(e == 13, "R8 R12 jump cycles", e, 13);

    // nested calls: depth 1..4 return, depth 5 overflows
    for (int d = 1; d <= 5; d++) begin
      int exp_e;
      clr();
      put3(0, 8'h79, 8'h00, 8'h10);
      put3(3, 8'hA1, 8'h03, 8'h01);
      mem[6] = 8'hFF;
      for (int k = 1; k <= d; k++) begin
        if (k < d) put3(16 * k, 8'h79, 8'h00, 16 * (k + 1));
        else       put3(16 * k, 8'hA1, 8'h03, 8'h00);
        mem[16 * k + 3] = 8'h09;
      end
      run(e, fw, pk);
      if (d <= 4) begin
        exp_e = 6 * d + 12;
        chk(mem[10'h300] == 8'h00, "R9 innermost reached", mem[10'h300], 0);
        chk(mem[10'h301] == 8'h00, "R9 returned to caller", mem[10'h301], 0);
      end else begin
        exp_e = 20;
        chk(mem[10'h300] == 8'hEE && mem[10'h301] == 8'hEE, "R10 overflow halts",
            {mem[10'h300], mem[10'h301]}, 16'hEEEE);
        chk(pk, "R10 held after overflow", pk, 1);
      end
      chk(e == exp_e, "R9 R12 call cycles", e, exp_e);
    end

    // return with empty stack
    clr();
    mem[0] = 8'h09;
    run(e, fw, pk);
    chk(e == 2 && fw == 0 && pk, "R10 empty return halts", e, 2);

    // bad index post-byte
    clr();
    mem[0] = 8'h85; mem[1] = 8'h42;
    run(e, fw, pk);
    chk(e == 3 && fw == 0 && pk, "R11 bad post-byte halts", e, 3);

    // every first byte outside the subset
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h81 || op == 8'hA1 || op == 8'h2C || op == 8'h11 || op == 8'h15 ||
          op == 8'h85 || op == 8'h73 || op == 8'h79 || op == 8'h60) continue;
      clr();
      mem[0] = 8'(op);
      mem[1] = 8'h02; mem[2] = 8'h00;
      run(e, fw, pk);
      chk(e == 2, "R11 illegal opcode halt edge", e, 2);
      chk(fw == 0 && pk, "R11 halted state held", {fw[7:0], 7'h0, pk}, 1);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule